// File: doc/BRIEF.md
# Time Interval Counter

This block keeps a free-running elapsed-time record and, next to it, a programmable interval timer. A one-cycle tick pulse arriving 128 times per second drives a chain of four cascaded counters: fractions of a second (1/128 s), seconds, minutes and hours. Each counter rolls over at its modulus and carries into the next.

The interval timer counts events of one selectable unit: a tick, a completed second, a completed minute or a completed hour. Each unit event is the rollover of the next lower time counter. When the count reaches the value held in the 8-bit limit register, a sticky interrupt flag is raised. The timer then either reloads and restarts, or stops and holds until software disables it. Software writes the control register, the limit register and all four time registers through one write port. The control register and the time and count values are visible on output ports.

Top module: `tic_unit`

## Requirements
- R1: While the time enable (control bit 0) is 1, each tick increments the fraction counter. From 127 it returns to 0 and advances the seconds counter in the same cycle.
- R2: Seconds and minutes return to 0 after 59, and hours return to 0 after 23. Each rollover advances the next counter in the same cycle, so a tick at 23:59:59 and fraction 127 leaves all four counters at 0.
- R3: While the time enable is 0, ticks are ignored: the four time counters and the interval count keep their values.
- R4: Control bits 5:4 select the unit of the interval timer: 0 = tick, 1 = fraction rollover (second), 2 = seconds rollover (minute), 3 = minutes rollover (hour). The count advances by one per event of the selected unit only.
- R5: The interrupt flag (`irq_o`, also control bit 2) is set on the clock edge at which the count reaches the limit register value.
- R6: With the one-shot bit (control bit 3) at 0, the count returns to 0 when it reaches the limit and keeps counting, so the flag condition recurs every limit events.
- R7: With the one-shot bit at 1, the count holds at the limit after it is reached, and further unit events are ignored.
- R8: While the interval enable (control bit 1) is 0, the count is held at 0. Clearing this bit also re-arms a stopped one-shot timer.
- R9: Once set, the flag stays set until a control write carries 0 in bit 2. A control write with 1 in bit 2 leaves the flag unchanged. If the flag is set and cleared in the same cycle, the set wins.
- R10: A software write to a time counter in the same cycle as a tick stores the written value in that counter. Counters that are not written still update from the tick.
- R11: Write select codes are 0 = control, 1 = limit, 2 = fraction, 3 = seconds, 4 = minutes, 5 = hours. All state resets to 0. `ctrl_o` reads back {00, unit[1:0], one-shot, flag, interval enable, time enable}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse at 128 Hz |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select for the write |
| wr_data_i | input | 8 | Write data |
| ctrl_o | output | 8 | Control register readback |
| count_o | output | 8 | Current interval count |
| frac_o | output | 8 | Elapsed 1/128 seconds |
| sec_o | output | 8 | Elapsed seconds |
| min_o | output | 8 | Elapsed minutes |
| hour_o | output | 8 | Elapsed hours |
| irq_o | output | 1 | Interval interrupt flag |

## Verification
The bench builds the block with its default parameters: 128 ticks per second, 60 seconds, 60 minutes, 24 hours and an 8-bit count. A full hour at that rate would take far too many ticks to run. Instead, the bench preloads the time counters through the write port just below a rollover. This brings the minute, hour and day rollovers, and the interval units that depend on them, within a few ticks. Random writes to the control and limit registers, mixed into tick streams, cover reload and one-shot behaviour, flag clearing, and collisions between writes and ticks.

// File: rtl/tic_pkg.sv
package tic_pkg;

    localparam int unsigned NUM_STAGES = 4;

    // register select codes on the write port
    localparam logic [2:0] SEL_CTRL  = 3'd0;
    localparam logic [2:0] SEL_LIMIT = 3'd1;
    localparam logic [2:0] SEL_FRAC  = 3'd2;

    // control register bit positions
    localparam int unsigned CB_TEN     = 0;
    localparam int unsigned CB_IEN     = 1;
    localparam int unsigned CB_FLAG    = 2;
    localparam int unsigned CB_ONESHOT = 3;
    localparam int unsigned CB_UNIT    = 4;

    typedef struct packed {
        logic [1:0] unit;
        logic       oneshot;
        logic       ien;
        logic       ten;
    } ctrl_t;

endpackage

// File: rtl/tic_stage.sv
module tic_stage #(
    parameter int unsigned MODULUS = 60,
    parameter int unsigned VAL_W   = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             inc_i,
    input  logic             wr_i,
    input  logic [VAL_W-1:0] wr_data_i,
    output logic [VAL_W-1:0] val_o,
    output logic             wrap_o
);
    localparam int unsigned CW = $clog2(MODULUS);
    localparam logic [CW-1:0] LAST = CW'(MODULUS - 1);

    typedef struct packed {
        logic [CW-1:0] val;
    } stage_t;

    stage_t st_d, st_q;

    assign wrap_o = inc_i && (st_q.val == LAST);
    assign val_o  = VAL_W'(st_q.val);

    always_comb begin
        st_d = st_q;
        if (inc_i) begin
            st_d.val = (st_q.val == LAST) ? '0 : st_q.val + 1'b1;
        end
        if (wr_i) begin
            st_d.val = wr_data_i[CW-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

endmodule

// File: rtl/tic_time_chain.sv
module tic_time_chain
    import tic_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 128,
    parameter int unsigned SEC_PER_MIN   = 60,
    parameter int unsigned MIN_PER_HOUR  = 60,
    parameter int unsigned HOURS_PER_DAY = 24,
    parameter int unsigned VAL_W         = 8
) (
    input  logic                                clk_i,
    input  logic                                rst_ni,
    input  logic                                inc_i,
    input  logic [NUM_STAGES-1:0]               wr_i,
    input  logic [VAL_W-1:0]                    wr_data_i,
    output logic [NUM_STAGES-1:0][VAL_W-1:0]    val_o,
    output logic [NUM_STAGES-1:0]               wrap_o
);
    function automatic int unsigned modulus_of(input int unsigned k);
        case (k)
            0:       return TICKS_PER_SEC;
            1:       return SEC_PER_MIN;
            2:       return MIN_PER_HOUR;
            default: return HOURS_PER_DAY;
        endcase
    endfunction

    logic [NUM_STAGES:0] carry;
    assign carry[0] = inc_i;

    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
        tic_stage #(
            .MODULUS (modulus_of(k)),
            .VAL_W   (VAL_W)
        ) stage_i (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .inc_i     (carry[k]),
            .wr_i      (wr_i[k]),
            .wr_data_i (wr_data_i),
            .val_o     (val_o[k]),
            .wrap_o    (wrap_o[k])
        );
        assign carry[k+1] = wrap_o[k];
    end

endmodule

// File: rtl/tic_interval.sv
module tic_interval
    import tic_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  en_i,
    input  logic                  oneshot_i,
    input  logic [1:0]            unit_i,
    input  logic [NUM_STAGES-1:0] ev_i,
    input  logic [CNT_W-1:0]      limit_i,
    input  logic                  clr_flag_i,
    output logic [CNT_W-1:0]      cnt_o,
    output logic                  flag_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             flag;
    } ivl_t;

    ivl_t st_d, st_q;
    logic             unit_ev;
    logic [CNT_W-1:0] cnt_inc;

    assign unit_ev = ev_i[unit_i];
    assign cnt_inc = st_q.cnt + 1'b1;
    assign cnt_o   = st_q.cnt;
    assign flag_o  = st_q.flag;

    always_comb begin
        st_d = st_q;
        if (clr_flag_i) begin
            st_d.flag = 1'b0;
        end
        if (!en_i) begin
            st_d.cnt  = '0;
            st_d.done = 1'b0;
        end else if (unit_ev && !st_q.done) begin
            if (cnt_inc == limit_i) begin
                st_d.flag = 1'b1;
                if (oneshot_i) begin
                    st_d.cnt  = cnt_inc;
                    st_d.done = 1'b1;
                end else begin
                    st_d.cnt  = '0;
                end
            end else begin
                st_d.cnt = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

endmodule

// File: rtl/tic_unit.sv
module tic_unit
    import tic_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 128,
    parameter int unsigned SEC_PER_MIN   = 60,
    parameter int unsigned MIN_PER_HOUR  = 60,
    parameter int unsigned HOURS_PER_DAY = 24,
    parameter int unsigned DATA_W        = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [7:0]        ctrl_o,
    output logic [DATA_W-1:0] count_o,
    output logic [DATA_W-1:0] frac_o,
    output logic [DATA_W-1:0] sec_o,
    output logic [DATA_W-1:0] min_o,
    output logic [DATA_W-1:0] hour_o,
    output logic              irq_o
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] limit;
    } top_t;

    top_t st_d, st_q;

    logic [NUM_STAGES-1:0]             wr_time;
    logic [NUM_STAGES-1:0][DATA_W-1:0] time_val;
    logic [NUM_STAGES-1:0]             wrap;
    logic [NUM_STAGES-1:0]             unit_ev;
    logic                              tick_en;
    logic                              clr_flag;

    assign tick_en  = tick_i && st_q.ctrl.ten;
    assign clr_flag = wr_en_i && (wr_sel_i == SEL_CTRL) && !wr_data_i[CB_FLAG];

    always_comb begin
        for (int k = 0; k < int'(NUM_STAGES); k++) begin
            wr_time[k] = wr_en_i && (wr_sel_i == (SEL_FRAC + 3'(k)));
        end
    end

    // unit event k is the increment request into stage k
    assign unit_ev = {wrap[NUM_STAGES-2:0], tick_en};

    always_comb begin
        st_d = st_q;
        if (wr_en_i && wr_sel_i == SEL_CTRL) begin
            st_d.ctrl.ten     = wr_data_i[CB_TEN];
            st_d.ctrl.ien     = wr_data_i[CB_IEN];
            st_d.ctrl.oneshot = wr_data_i[CB_ONESHOT];
            st_d.ctrl.unit    = wr_data_i[CB_UNIT +: 2];
        end
        if (wr_en_i && wr_sel_i == SEL_LIMIT) begin
            st_d.limit = wr_data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    tic_time_chain #(
        .TICKS_PER_SEC (TICKS_PER_SEC),
        .SEC_PER_MIN   (SEC_PER_MIN),
        .MIN_PER_HOUR  (MIN_PER_HOUR),
        .HOURS_PER_DAY (HOURS_PER_DAY),
        .VAL_W         (DATA_W)
    ) chain_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .inc_i     (tick_en),
        .wr_i      (wr_time),
        .wr_data_i (wr_data_i),
        .val_o     (time_val),
        .wrap_o    (wrap)
    );

    tic_interval #(
        .CNT_W (DATA_W)
    ) ivl_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (st_q.ctrl.ien),
        .oneshot_i  (st_q.ctrl.oneshot),
        .unit_i     (st_q.ctrl.unit),
        .ev_i       (unit_ev),
        .limit_i    (st_q.limit),
        .clr_flag_i (clr_flag),
        .cnt_o      (count_o),
        .flag_o     (irq_o)
    );

    assign frac_o = time_val[0];
    assign sec_o  = time_val[1];
    assign min_o  = time_val[2];
    assign hour_o = time_val[3];
    assign ctrl_o = {2'b00, st_q.ctrl.unit, st_q.ctrl.oneshot, irq_o,
                     st_q.ctrl.ien, st_q.ctrl.ten};

endmodule

// File: rtl/tic_unit_chk.sv
module tic_unit_chk #(
    parameter int unsigned TICKS_PER_SEC = 128,
    parameter int unsigned HOURS_PER_DAY = 24,
    parameter int unsigned DATA_W        = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              tick_i,
    input logic              wr_en_i,
    input logic [2:0]        wr_sel_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic [DATA_W-1:0] count_o,
    input logic [DATA_W-1:0] frac_o,
    input logic [DATA_W-1:0] sec_o,
    input logic [DATA_W-1:0] min_o,
    input logic [DATA_W-1:0] hour_o,
    input logic              irq_o,
    input logic              ten_i,
    input logic              ien_i
);
    AST_FRAC_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frac_o < DATA_W'(TICKS_PER_SEC)); // R1

    AST_TICK_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ten_i && tick_i && !wr_en_i && frac_o < DATA_W'(TICKS_PER_SEC - 1))
        |=> (frac_o == $past(frac_o) + 1'b1)); // R1

    AST_HOUR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_en_i || wr_sel_i != 3'd5 || wr_data_i < DATA_W'(HOURS_PER_DAY))
        |=> hour_o < DATA_W'(HOURS_PER_DAY)); // R2

    AST_STOPPED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ten_i && !wr_en_i && ien_i)
        |=> ($stable(frac_o) && $stable(sec_o) && $stable(min_o)
             && $stable(hour_o) && $stable(count_o))); // R3

    AST_DISABLE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ien_i |=> (count_o == '0)); // R8

    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && !(wr_en_i && wr_sel_i == 3'd0 && !wr_data_i[2])) |=> irq_o); // R9

endmodule

bind tic_unit tic_unit_chk #(
    .TICKS_PER_SEC (TICKS_PER_SEC),
    .HOURS_PER_DAY (HOURS_PER_DAY),
    .DATA_W        (DATA_W)
) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .count_o   (count_o),
    .frac_o    (frac_o),
    .sec_o     (sec_o),
    .min_o     (min_o),
    .hour_o    (hour_o),
    .irq_o     (irq_o),
    .ten_i     (st_q.ctrl.ten),
    .ien_i     (st_q.ctrl.ien)
);

// File: tb/tic_unit_tb_top.sv
module tic_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] ctrl_o, count_o, frac_o, sec_o, min_o, hour_o;
    logic       irq_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    tic_unit dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .tick_i    (tick),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_data_i (wr_data),
        .ctrl_o    (ctrl_o),
        .count_o   (count_o),
        .frac_o    (frac_o),
        .sec_o     (sec_o),
        .min_o     (min_o),
        .hour_o    (hour_o),
        .irq_o     (irq_o)
    );

    // reference state
    int mods[4] = '{128, 60, 60, 24};
    int m_t[4];
    bit m_ten, m_ien, m_one, m_flag, m_done;
    int m_unit, m_cnt, m_limit;

    function automatic logic [7:0] mk_ctrl(bit ten, bit ien, bit keep, bit one, int unit);
        return {2'b00, 2'(unit), one, keep, ien, ten};
    endfunction

    task automatic model_step(bit tk, bit we, int sel, logic [7:0] dat);
        bit ev[4];
        int nt[4];
        bit set_f;
        int n;
        set_f = 1'b0;
        nt = m_t;
        ev = '{default: 1'b0};
        ev[0] = tk && m_ten;
        for (int k = 0; k < 4; k++) begin
            if (ev[k]) begin
                if (m_t[k] == mods[k] - 1) begin
                    nt[k] = 0;
                    if (k < 3) ev[k+1] = 1'b1;
                end else begin
                    nt[k] = m_t[k] + 1;
                end
            end
        end
        if (!m_ien) begin
            m_cnt = 0;
            m_done = 1'b0;
        end else if (ev[m_unit] && !m_done) begin
            n = (m_cnt + 1) % 256;
            if (n == m_limit) begin
                set_f = 1'b1;
                if (m_one) begin
                    m_cnt = n;
                    m_done = 1'b1;
                end else begin
                    m_cnt = 0;
                end
            end else begin
                m_cnt = n;
            end
        end
        if (we && sel == 0 && !dat[2]) m_flag = 1'b0;
        if (set_f) m_flag = 1'b1;
        if (we) begin
            case (sel)
                0: begin
                    m_ten = dat[0]; m_ien = dat[1]; m_one = dat[3]; m_unit = int'(dat[5:4]);
                end
                1: m_limit = int'(dat);
                2, 3, 4, 5: nt[sel-2] = int'(dat);
                default: ;
            endcase
        end
        m_t = nt;
    endtask

    task automatic chk(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        chk(tag, "frac", int'(frac_o), m_t[0]);
        chk(tag, "sec", int'(sec_o), m_t[1]);
        chk(tag, "min", int'(min_o), m_t[2]);
        chk(tag, "hour", int'(hour_o), m_t[3]);
        chk(tag, "count", int'(count_o), m_cnt);
        chk(tag, "irq", int'(irq_o), int'(m_flag));
        chk(tag, "ctrl", int'(ctrl_o), int'(mk_ctrl(m_ten, m_ien, m_flag, m_one, m_unit)));
    endtask

    // one clock cycle of stimulus, driven at the falling edge, checked one cycle later
    task automatic op(bit tk, bit we, int sel, logic [7:0] dat, string tag);
        tick = tk;
        wr_en = we;
        wr_sel = 3'(sel);
        wr_data = dat;
        @(negedge clk);
        tick = 1'b0;
        wr_en = 1'b0;
        model_step(tk, we, sel, dat);
        compare_all(tag);
    endtask

    task automatic ticks(int n, string tag);
        for (int i = 0; i < n; i++) op(1'b1, 1'b0, 0, 8'h00, tag);
    endtask

    task automatic wr(int sel, logic [7:0] dat, string tag);
        op(1'b0, 1'b1, sel, dat, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int r;
        m_t = '{0, 0, 0, 0};
        m_ten = 0; m_ien = 0; m_one = 0; m_flag = 0; m_done = 0;
        m_unit = 0; m_cnt = 0; m_limit = 0;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R11 reset");

        // R11: control readback; R1: fraction count and carry
        wr(0, mk_ctrl(1, 0, 1, 0, 0), "R11 ctrl write");
        ticks(130, "R1 fraction count");

        // R2: full day rollover
        wr(2, 8'd127, "R2 preload");
        wr(3, 8'd59, "R2 preload");
        wr(4, 8'd59, "R2 preload");
        wr(5, 8'd23, "R2 preload");
        ticks(1, "R2 day rollover");
        ticks(3, "R2 after rollover");

        // R3: stopped clock ignores ticks
        wr(0, mk_ctrl(0, 1, 1, 0, 0), "R3 stop");
        wr(1, 8'd2, "R3 limit");
        ticks(5, "R3 ticks ignored");
        wr(0, mk_ctrl(1, 0, 1, 0, 0), "R3 restart");

        // R10: write and tick in the same cycle
        wr(3, 8'd59, "R10 preload");
        wr(2, 8'd127, "R10 preload");
        op(1'b1, 1'b1, 2, 8'd5, "R10 write wins");

        // R5 / R7: one-shot on ticks
        wr(1, 8'd3, "R7 limit");
        wr(0, mk_ctrl(1, 1, 1, 1, 0), "R7 arm");
        ticks(2, "R5 before limit");
        ticks(1, "R5 flag at limit");
        ticks(4, "R7 held at limit");

        // R9: flag sticky, keep write, clear write
        wr(0, mk_ctrl(1, 1, 1, 1, 0), "R9 keep flag");
        ticks(2, "R9 flag sticky");
        wr(0, mk_ctrl(1, 1, 0, 1, 0), "R9 clear flag");
        ticks(2, "R9 stays clear");

        // R8: disable clears and re-arms
        wr(0, mk_ctrl(1, 0, 1, 1, 0), "R8 disable");
        ticks(2, "R8 held at zero");

        // R6: reload mode
        wr(1, 8'd2, "R6 limit");
        wr(0, mk_ctrl(1, 1, 1, 0, 0), "R6 arm");
        ticks(1, "R6 count");
        ticks(1, "R6 first expiry");
        wr(0, mk_ctrl(1, 1, 0, 0, 0), "R6 clear");
        ticks(1, "R6 counting again");
        ticks(1, "R6 second expiry");

        // R4: unit selection
        wr(0, mk_ctrl(1, 0, 0, 0, 1), "R4 unit1 setup");
        wr(1, 8'd1, "R4 limit");
        wr(0, mk_ctrl(1, 1, 1, 1, 1), "R4 unit1 arm");
        wr(2, 8'd126, "R4 preload");
        ticks(1, "R4 no second yet");
        ticks(1, "R4 second event");
        wr(0, mk_ctrl(1, 0, 0, 0, 2), "R4 unit2 setup");
        wr(0, mk_ctrl(1, 1, 1, 1, 2), "R4 unit2 arm");
        wr(3, 8'd59, "R4 preload");
        wr(2, 8'd127, "R4 preload");
        ticks(1, "R4 minute event");
        wr(0, mk_ctrl(1, 0, 0, 0, 3), "R4 unit3 setup");
        wr(0, mk_ctrl(1, 1, 1, 1, 3), "R4 unit3 arm");
        wr(4, 8'd59, "R4 preload");
        wr(3, 8'd59, "R4 preload");
        wr(2, 8'd127, "R4 preload");
        ticks(1, "R4 hour event");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            r = int'($urandom_range(0, 99));
            if (r < 70) begin
                ticks(1, "R4 random tick");
            end else if (r < 80) begin
                wr(0, mk_ctrl($urandom_range(0, 9) != 0, $urandom_range(0, 3) != 0,
                              $urandom_range(0, 2) != 0, 1'($urandom_range(0, 1)),
                              int'($urandom_range(0, 1))), "R9 random ctrl");
            end else if (r < 86) begin
                wr(1, 8'($urandom_range(1, 6)), "R6 random limit");
            end else begin
                int s;
                s = int'($urandom_range(2, 5));
                op(1'b1, 1'b1, s, 8'($urandom_range(0, mods[s-2] - 1)), "R10 random write");
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule